// File: doc/BRIEF.md
# Cluster Memory Request Switch

This block connects the sixteen processing elements of one 4x4 cluster to the sixteen memory banks of that cluster. The banks share one address space. It also gives the cluster a single exit toward the inter-cluster router. Each element has its own judge stage, which reads the request address and sends the request one of three ways:

- A request for the element's own bank goes straight to that bank and is served at once.
- A request for any other bank in the cluster passes first through the line controller of the element's line, then through the column controller of the target bank.
- A request for another cluster goes through the element's line controller to a router controller.

Every point where requests can meet picks a winner at random, using a per-arbiter LFSR. A request that loses keeps `req_ready` low and stays presented until it is taken. Banks sit at the boundary as single-cycle ports: the enable, write flag, word offset and write data leave the block in the cycle the request is granted, and the read word comes back in the next cycle. For every accepted request, the switch raises a one-cycle `resp_valid` toward the element that issued it. That element is identified by the bank's captured source index, or by the index returned with a router answer. An element keeps at most one request outstanding and holds its request stable until `req_ready` is seen.

Top module: `cms_switch`

## Requirements
- R1: A request address is, from MSB to LSB, {cluster (2 bits), line (2 bits), column (2 bits), word offset (3 bits)}. Bank index and element index are both line*4+column. Element p's own bank is bank p. A cluster field unequal to `LOCAL_CL` (default 1) marks the request as off-cluster.
- R2: A valid request from element p for its own bank, inside the local cluster, sees `req_ready[p]` high in the same cycle. `resp_valid[p]` then follows in the very next cycle.
- R3: No bank takes more than one access per cycle. When a bank's own element presents a request, that element wins the bank over every remote requester.
- R4: A granted in-cluster request drives `bank_en`, `bank_we`, `bank_off` (the word offset) and `bank_wdata` of the addressed bank, and only of that bank. The written data therefore lands at that bank and offset.
- R5: When several requests contend for one bank, exactly one of them is granted per cycle. Each loser sees `req_ready` low, keeps its request, and is granted in a later cycle. No request is dropped.
- R6: An off-cluster request appears on the router port with `rtr_addr`, `rtr_we` and `rtr_wdata` equal to the request and `rtr_src` equal to the element index. At most one request is offered per cycle. While `rtr_ready` is low, `rtr_valid` stays high.
- R7: Every accepted request produces exactly one `resp_valid` pulse at its requester, in the cycle after acceptance for bank accesses. Read data is the addressed bank's `bank_rdata` for in-cluster reads, or `rtr_resp_rdata` when `rtr_resp_src` names the element.
- R8: While reset is high and no request is presented, `resp_valid`, `bank_en` and `rtr_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 16 | Per-element request valid |
| req_we | input | 16 | Per-element write flag |
| req_addr | input | 16x9 | Per-element address {cluster, line, column, offset} |
| req_wdata | input | 16x32 | Per-element write data |
| req_ready | output | 16 | Request taken this cycle |
| resp_valid | output | 16 | One-cycle completion pulse per element |
| resp_rdata | output | 16x32 | Read data returned to each element |
| bank_en | output | 16 | Bank access enable |
| bank_we | output | 16 | Bank write enable |
| bank_off | output | 16x3 | Word offset inside the bank |
| bank_wdata | output | 16x32 | Bank write data |
| bank_rdata | input | 16x32 | Bank read word, one cycle after `bank_en` |
| rtr_valid | output | 1 | Off-cluster request offered to the router |
| rtr_we | output | 1 | Off-cluster write flag |
| rtr_addr | output | 9 | Off-cluster address |
| rtr_wdata | output | 32 | Off-cluster write data |
| rtr_src | output | 4 | Index of the element that issued the offered request |
| rtr_ready | input | 1 | Router takes the offered request |
| rtr_resp_valid | input | 1 | Router answer valid |
| rtr_resp_src | input | 4 | Element the router answer belongs to |
| rtr_resp_rdata | input | 32 | Router answer data |

## Verification
The bench aims sixteen simultaneous requests at one bank whose own element also requests it. A switch that let a remote request beat the owner would delay that owner's completion. A switch that discarded losers would leave elements with no response, so the run would never finish.

A wrong bank or offset decode would show up in two places: words read back by their owners, and the bench's bank model compared word by word against a shadow copy at the end.

Off-cluster traffic runs against a router that stalls at random. A wrong `rtr_src` would send the answer to a different element. That element would then see a response it never asked for, which the bench reports, and it would also show up as a data mismatch.

A response that arrived a cycle late or twice would be caught by the cycle-exact expectation placed on every completion.

// File: rtl/cms_pkg.sv
package cms_pkg;

    parameter int SIDE    = 4;
    parameter int IDX_W   = 2;
    parameter int NPE     = SIDE * SIDE;
    parameter int PE_W    = 2 * IDX_W;
    parameter int DATA_W  = 32;
    parameter int OFF_W   = 3;
    parameter int CL_W    = 2;
    parameter int ADDR_W  = CL_W + 2 * IDX_W + OFF_W;
    parameter int LFSR_W  = 16;

    // Address layout, MSB first
    typedef struct packed {
        logic [CL_W-1:0]  cl;
        logic [IDX_W-1:0] line;
        logic [IDX_W-1:0] col;
        logic [OFF_W-1:0] off;
    } addr_t;

    typedef logic [SIDE-1:0] vec_t;

    typedef enum logic [1:0] {
        ROUTE_NONE,
        ROUTE_LOCAL,
        ROUTE_BANK,
        ROUTE_OFF
    } route_e;

    // Judge decision for one element
    function automatic route_e classify(logic v, addr_t a, logic [CL_W-1:0] here,
                                        logic [PE_W-1:0] me);
        route_e r;
        if (!v)                         r = ROUTE_NONE;
        else if (a.cl != here)          r = ROUTE_OFF;
        else if ({a.line, a.col} == me) r = ROUTE_LOCAL;
        else                            r = ROUTE_BANK;
        return r;
    endfunction

    // Pick the first requester at or after a random start position
    function automatic vec_t rand_pick(vec_t req, logic [IDX_W-1:0] start);
        vec_t g;
        logic hit;
        logic [IDX_W-1:0] i;
        g   = '0;
        hit = 1'b0;
        for (int k = 0; k < SIDE; k++) begin
            i = start + IDX_W'(k);
            if (req[i] && !hit) begin
                g[i] = 1'b1;
                hit  = 1'b1;
            end
        end
        return g;
    endfunction

endpackage

// File: rtl/cms_lfsr.sv
module cms_lfsr
    import cms_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'h0001
) (
    input  logic              clk,
    input  logic              rst,
    output logic [LFSR_W-1:0] rnd
);
    logic fb;

    assign fb = rnd[15] ^ rnd[13] ^ rnd[12] ^ rnd[10];

    always_ff @(posedge clk) begin
        if (rst) rnd <= SEED;
        else     rnd <= {rnd[LFSR_W-2:0], fb};
    end
endmodule

// File: rtl/cms_line_ctrl.sv
module cms_line_ctrl
    import cms_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'h1001
) (
    input  logic                        clk,
    input  logic                        rst,
    input  vec_t                        bank_req,
    input  logic [SIDE-1:0][IDX_W-1:0]  tgt_col,
    input  vec_t                        off_req,
    output vec_t                        col_vld,
    output logic [SIDE-1:0][SIDE-1:0]   col_sel,
    output logic                        off_vld,
    output vec_t                        off_sel
);
    logic [LFSR_W-1:0] rnd;
    vec_t              mask [SIDE];

    cms_lfsr #(.SEED(SEED)) lfsr_i (.clk(clk), .rst(rst), .rnd(rnd));

    for (genvar c = 0; c < SIDE; c++) begin : g_col
        for (genvar k = 0; k < SIDE; k++) begin : g_mem
            assign mask[c][k] = bank_req[k] && (tgt_col[k] == IDX_W'(c));
        end
        assign col_vld[c] = |mask[c];
        assign col_sel[c] = rand_pick(mask[c], rnd[2*c +: 2]);

        // R5: a column with candidates forwards exactly one of them
        p_col_one_r5: assert property (@(posedge clk) disable iff (rst)
            col_vld[c] |-> ($countones(col_sel[c]) == 1));
    end

    assign off_vld = |off_req;
    assign off_sel = rand_pick(off_req, rnd[9:8]);
endmodule

// File: rtl/cms_row_ctrl.sv
module cms_row_ctrl
    import cms_pkg::*;
#(
    parameter logic [LFSR_W-1:0] SEED = 16'h2001
) (
    input  logic                        clk,
    input  logic                        rst,
    input  vec_t                        cand_vld,
    input  logic [SIDE-1:0][IDX_W-1:0]  cand_tgt,
    input  vec_t                        own_req,
    output logic [SIDE-1:0][SIDE-1:0]   win
);
    logic [LFSR_W-1:0] rnd;
    vec_t              mask [SIDE];

    cms_lfsr #(.SEED(SEED)) lfsr_i (.clk(clk), .rst(rst), .rnd(rnd));

    for (genvar b = 0; b < SIDE; b++) begin : g_bank
        for (genvar l = 0; l < SIDE; l++) begin : g_line
            assign mask[b][l] = cand_vld[l] && (cand_tgt[l] == IDX_W'(b)) && !own_req[b];
        end
        assign win[b] = rand_pick(mask[b], rnd[2*b +: 2]);
    end
endmodule

// File: rtl/cms_switch.sv
module cms_switch
    import cms_pkg::*;
#(
    parameter logic [CL_W-1:0]   LOCAL_CL = 2'd1,
    parameter logic [LFSR_W-1:0] SEED     = 16'hACE1
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NPE-1:0]                 req_valid,
    input  logic [NPE-1:0]                 req_we,
    input  logic [NPE-1:0][ADDR_W-1:0]     req_addr,
    input  logic [NPE-1:0][DATA_W-1:0]     req_wdata,
    output logic [NPE-1:0]                 req_ready,
    output logic [NPE-1:0]                 resp_valid,
    output logic [NPE-1:0][DATA_W-1:0]     resp_rdata,
    output logic [NPE-1:0]                 bank_en,
    output logic [NPE-1:0]                 bank_we,
    output logic [NPE-1:0][OFF_W-1:0]      bank_off,
    output logic [NPE-1:0][DATA_W-1:0]     bank_wdata,
    input  logic [NPE-1:0][DATA_W-1:0]     bank_rdata,
    output logic                           rtr_valid,
    output logic                           rtr_we,
    output logic [ADDR_W-1:0]              rtr_addr,
    output logic [DATA_W-1:0]              rtr_wdata,
    output logic [PE_W-1:0]                rtr_src,
    input  logic                           rtr_ready,
    input  logic                           rtr_resp_valid,
    input  logic [PE_W-1:0]                rtr_resp_src,
    input  logic [DATA_W-1:0]              rtr_resp_rdata
);
    // ---------------- judge stage ----------------
    addr_t          a        [NPE];
    route_e         rt       [NPE];
    logic [NPE-1:0] local_req, remote_req, off_req;

    for (genvar p = 0; p < NPE; p++) begin : g_judge
        assign a[p]          = addr_t'(req_addr[p]);
        assign rt[p]         = classify(req_valid[p], a[p], LOCAL_CL, PE_W'(p));
        assign local_req[p]  = (rt[p] == ROUTE_LOCAL);
        assign remote_req[p] = (rt[p] == ROUTE_BANK);
        assign off_req[p]    = (rt[p] == ROUTE_OFF);
    end

    // ---------------- line controllers ----------------
    vec_t                        ln_bank [SIDE];
    vec_t                        ln_off  [SIDE];
    logic [SIDE-1:0][IDX_W-1:0]  ln_col  [SIDE];
    vec_t                        lc_vld  [SIDE];
    logic [SIDE-1:0][SIDE-1:0]   lc_sel  [SIDE];
    vec_t                        lc_offv;
    vec_t                        lc_offs [SIDE];

    for (genvar l = 0; l < SIDE; l++) begin : g_line
        for (genvar k = 0; k < SIDE; k++) begin : g_mem
            assign ln_bank[l][k] = remote_req[l*SIDE+k];
            assign ln_off[l][k]  = off_req[l*SIDE+k];
            assign ln_col[l][k]  = a[l*SIDE+k].col;
        end
        cms_line_ctrl #(.SEED((SEED ^ (16'(l + 1) * 16'h1357)) | 16'h0001)) line_i (
            .clk     (clk),
            .rst     (rst),
            .bank_req(ln_bank[l]),
            .tgt_col (ln_col[l]),
            .off_req (ln_off[l]),
            .col_vld (lc_vld[l]),
            .col_sel (lc_sel[l]),
            .off_vld (lc_offv[l]),
            .off_sel (lc_offs[l])
        );
    end

    // ---------------- row (column) controllers ----------------
    vec_t                        rc_vld [SIDE];
    logic [SIDE-1:0][IDX_W-1:0]  rc_tgt [SIDE];
    vec_t                        rc_own [SIDE];
    logic [SIDE-1:0][SIDE-1:0]   rc_win [SIDE];

    always_comb begin
        for (int c = 0; c < SIDE; c++) begin
            for (int l = 0; l < SIDE; l++) begin
                rc_vld[c][l] = lc_vld[l][c];
                rc_tgt[c][l] = '0;
                for (int k = 0; k < SIDE; k++) begin
                    if (lc_sel[l][c][k]) rc_tgt[c][l] = a[l*SIDE+k].line;
                end
                rc_own[c][l] = local_req[l*SIDE+c];
            end
        end
    end

    for (genvar c = 0; c < SIDE; c++) begin : g_row
        cms_row_ctrl #(.SEED((SEED ^ (16'(c + 1) * 16'h2468)) | 16'h0001)) row_i (
            .clk     (clk),
            .rst     (rst),
            .cand_vld(rc_vld[c]),
            .cand_tgt(rc_tgt[c]),
            .own_req (rc_own[c]),
            .win     (rc_win[c])
        );
    end

    // ---------------- bank drive ----------------
    logic [NPE-1:0]  bank_hit;
    logic [PE_W-1:0] bank_src [NPE];
    logic [NPE-1:0]  bank_gnt;

    always_comb begin
        for (int b = 0; b < SIDE; b++) begin
            for (int c = 0; c < SIDE; c++) begin
                bank_hit[b*SIDE+c] = 1'b0;
                bank_src[b*SIDE+c] = '0;
                if (local_req[b*SIDE+c]) begin
                    bank_hit[b*SIDE+c] = 1'b1;
                    bank_src[b*SIDE+c] = PE_W'(b*SIDE+c);
                end else begin
                    for (int l = 0; l < SIDE; l++) begin
                        for (int k = 0; k < SIDE; k++) begin
                            if (rc_win[c][b][l] && lc_sel[l][c][k]) begin
                                bank_hit[b*SIDE+c] = 1'b1;
                                bank_src[b*SIDE+c] = PE_W'(l*SIDE+k);
                            end
                        end
                    end
                end
            end
        end
        bank_gnt = '0;
        for (int q = 0; q < NPE; q++) begin
            bank_en[q]    = bank_hit[q];
            bank_we[q]    = bank_hit[q] && req_we[bank_src[q]];
            bank_off[q]   = a[bank_src[q]].off;
            bank_wdata[q] = req_wdata[bank_src[q]];
            if (bank_hit[q]) bank_gnt[bank_src[q]] = 1'b1;
        end
    end

    // ---------------- router controller ----------------
    logic [LFSR_W-1:0] rr_rnd;
    vec_t              rr_pick;
    logic [PE_W-1:0]   rr_src;

    cms_lfsr #(.SEED((SEED ^ 16'h5A5A) | 16'h0001)) rr_lfsr_i (
        .clk(clk), .rst(rst), .rnd(rr_rnd)
    );

    assign rr_pick = rand_pick(lc_offv, rr_rnd[1:0]);

    always_comb begin
        rr_src = '0;
        for (int l = 0; l < SIDE; l++) begin
            for (int k = 0; k < SIDE; k++) begin
                if (rr_pick[l] && lc_offs[l][k]) rr_src = PE_W'(l*SIDE+k);
            end
        end
    end

    assign rtr_valid = |lc_offv;
    assign rtr_src   = rr_src;
    assign rtr_we    = req_we[rr_src];
    assign rtr_addr  = req_addr[rr_src];
    assign rtr_wdata = req_wdata[rr_src];

    always_comb begin
        req_ready = bank_gnt;
        if (rtr_valid && rtr_ready) req_ready[rr_src] = 1'b1;
    end

    // ---------------- response return ----------------
    logic [NPE-1:0]  pend_q;
    logic [PE_W-1:0] src_q [NPE];

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
        end else begin
            pend_q <= bank_hit;
        end
        for (int q = 0; q < NPE; q++) src_q[q] <= bank_src[q];
    end

    always_comb begin
        for (int p = 0; p < NPE; p++) begin
            resp_valid[p] = 1'b0;
            resp_rdata[p] = '0;
            for (int q = 0; q < NPE; q++) begin
                if (pend_q[q] && src_q[q] == PE_W'(p)) begin
                    resp_valid[p] = 1'b1;
                    resp_rdata[p] = bank_rdata[q];
                end
            end
            if (rtr_resp_valid && rtr_resp_src == PE_W'(p)) begin
                resp_valid[p] = 1'b1;
                resp_rdata[p] = rtr_resp_rdata;
            end
        end
    end

    // ---------------- assertions ----------------
    logic [NPE-1:0] tq    [NPE];
    logic [NPE-1:0] owed;

    always_comb begin
        for (int q = 0; q < NPE; q++) begin
            for (int p = 0; p < NPE; p++) begin
                tq[q][p] = req_valid[p] && req_ready[p] && (a[p].cl == LOCAL_CL) &&
                           ({a[p].line, a[p].col} == PE_W'(q));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) owed <= '0;
        else     owed <= (owed & ~resp_valid) | (req_valid & req_ready);
    end

    for (genvar q = 0; q < NPE; q++) begin : g_chk
        p_bank_single_r3: assert property (@(posedge clk) disable iff (rst)
            $countones(tq[q]) <= 1);
        p_bank_addr_r4: assert property (@(posedge clk) disable iff (rst)
            bank_en[q] |-> (|tq[q]));
        p_local_next_r2: assert property (@(posedge clk) disable iff (rst)
            (req_valid[q] && req_ready[q] && rt[q] == ROUTE_LOCAL) |=> resp_valid[q]);
        p_resp_owed_r7: assert property (@(posedge clk) disable iff (rst)
            resp_valid[q] |-> owed[q]);
    end

    p_rtr_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (rtr_valid && !rtr_ready) |=> rtr_valid);
endmodule

// File: tb/cms_switch_tb.sv
module cms_switch_tb_top;
    import cms_pkg::*;

    localparam logic [CL_W-1:0] HERE = 2'd1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    logic [NPE-1:0]             req_valid = '0, req_we = '0, req_ready;
    logic [NPE-1:0][ADDR_W-1:0] req_addr  = '0;
    logic [NPE-1:0][DATA_W-1:0] req_wdata = '0;
    logic [NPE-1:0]             resp_valid;
    logic [NPE-1:0][DATA_W-1:0] resp_rdata;
    logic [NPE-1:0]             bank_en, bank_we;
    logic [NPE-1:0][OFF_W-1:0]  bank_off;
    logic [NPE-1:0][DATA_W-1:0] bank_wdata;
    logic [NPE-1:0][DATA_W-1:0] bank_rdata;
    logic                       rtr_valid, rtr_we;
    logic [ADDR_W-1:0]          rtr_addr;
    logic [DATA_W-1:0]          rtr_wdata;
    logic [PE_W-1:0]            rtr_src;
    logic                       rtr_ready = 1'b0;
    logic                       rtr_resp_valid = 1'b0;
    logic [PE_W-1:0]            rtr_resp_src = '0;
    logic [DATA_W-1:0]          rtr_resp_rdata = '0;

    cms_switch #(.LOCAL_CL(HERE)) dut_i (.*);

    // bank model: write and read in the enable cycle, read word valid next cycle
    logic [DATA_W-1:0] mem [NPE][1<<OFF_W];
    always_ff @(posedge clk) begin
        for (int q = 0; q < NPE; q++) begin
            if (bank_en[q]) begin
                if (bank_we[q]) mem[q][bank_off[q]] <= bank_wdata[q];
                bank_rdata[q] <= mem[q][bank_off[q]];
            end
        end
    end

    int nchk = 0, nfail = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] shadow [NPE][1<<OFF_W];
    bit   acc [NPE], waitr [NPE], first [NPE], is_loc [NPE], is_off [NPE], chk [NPE];
    int   left [NPE];
    logic [DATA_W-1:0] expd [NPE];
    int   wb [NPE], wo [NPE];
    bit   rtr_acc = 1'b0;
    logic [PE_W-1:0]   rtr_lsrc;
    logic [DATA_W-1:0] rtr_ldata;

    function automatic logic [DATA_W-1:0] rf(logic [ADDR_W-1:0] ad);
        return 32'hC0DE0000 ^ DATA_W'(ad);
    endfunction

    task automatic fail(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        nfail++;
        $display("FAIL %s actual=%h expected=%h", req, act, exp);
    endtask

    task automatic gen_op(input int p, input int mode);
        int b, o, r;
        logic [CL_W-1:0] cl;
        bit we;
        cl = HERE; b = p; o = p / 2; we = 1'b0;
        case (mode)
            0: we = 1'b1;
            1: we = 1'b0;
            2: begin b = 5; o = p % 8; end
            3: begin cl = (p % 2 == 1) ? 2'd0 : 2'd3; o = p % 8; we = (p % 3 == 0); end
            default: begin
                r = int'($urandom % 8);
                we = $urandom % 2 == 1;
                if (r >= 2 && r <= 5) b = int'($urandom % 16);
                if (r == 6) cl = CL_W'((($urandom % 3) + 2) % 4);
                if (we) begin
                    b = (b & ~1) | (p & 1);
                    o = p / 2;
                end else o = int'($urandom % 8);
            end
        endcase
        // R1: {cluster, line, column, offset}
        req_addr[p]  = {cl, PE_W'(b), OFF_W'(o)};
        req_we[p]    = we;
        req_wdata[p] = $urandom;
        is_off[p]    = (cl != HERE);
        is_loc[p]    = !is_off[p] && b == p;
        wb[p] = b; wo[p] = o;
        chk[p] = 1'b0;
        if (!we && is_off[p]) begin chk[p] = 1'b1; expd[p] = rf(req_addr[p]); end
        if (!we && !is_off[p] && o == p / 2 && (b % 2) == (p % 2)) begin
            chk[p] = 1'b1; expd[p] = shadow[b][o];
        end
    endtask

    task automatic run_phase(input int mode, input int nops);
        bit busy;
        for (int p = 0; p < NPE; p++) left[p] = nops;
        busy = 1'b1;
        while (busy && !finished) begin
            @(negedge clk);
            // A: retire acceptances of the last edge
            for (int p = 0; p < NPE; p++) begin
                waitr[p] = acc[p];
                if (acc[p]) begin req_valid[p] = 1'b0; acc[p] = 1'b0; end
            end
            // B: router model answers one cycle after taking a request
            rtr_resp_valid = rtr_acc;
            rtr_resp_src   = rtr_lsrc;
            rtr_resp_rdata = rtr_ldata;
            rtr_acc        = 1'b0;
            rtr_ready      = ($urandom % 3) != 0;
            // C: issue
            for (int p = 0; p < NPE; p++) begin
                if (!req_valid[p] && !waitr[p] && left[p] > 0 && (mode < 4 || $urandom % 4 != 0)) begin
                    gen_op(p, mode);
                    req_valid[p] = 1'b1;
                    first[p] = 1'b1;
                    left[p]--;
                end
            end
            #1;
            // E: responses must arrive exactly in the cycle after acceptance (R7)
            for (int p = 0; p < NPE; p++) begin
                if (waitr[p]) begin
                    nchk++;
                    if (!resp_valid[p]) fail($sformatf("R7 no response pe%0d", p), 0, 1);
                    else if (chk[p] && resp_rdata[p] !== expd[p])
                        fail(is_off[p] ? "R6 router read data" : "R4 bank read data", resp_rdata[p], expd[p]);
                    if (req_we[p] && !is_off[p]) shadow[wb[p]][wo[p]] = req_wdata[p];
                end else if (resp_valid[p]) begin
                    nchk++;
                    fail($sformatf("R7 spurious response pe%0d", p), 1, 0);
                end
            end
            // F: sample grants
            for (int p = 0; p < NPE; p++) begin
                if (req_valid[p]) begin
                    if (first[p] && is_loc[p]) begin
                        nchk++;
                        if (!req_ready[p]) fail($sformatf("R2 local not immediate pe%0d", p), 0, 1);
                    end
                    first[p] = 1'b0;
                    if (req_ready[p]) acc[p] = 1'b1;
                end
            end
            if (rtr_valid && rtr_ready) begin
                nchk++;
                if (!req_valid[rtr_src] || req_addr[rtr_src] !== rtr_addr || !is_off[rtr_src])
                    fail("R6 router source", DATA_W'(rtr_addr), DATA_W'(req_addr[rtr_src]));
                rtr_acc   = 1'b1;
                rtr_lsrc  = rtr_src;
                rtr_ldata = rtr_we ? '0 : rf(rtr_addr);
            end
            busy = 1'b0;
            for (int p = 0; p < NPE; p++)
                if (left[p] > 0 || req_valid[p] || acc[p] || waitr[p]) busy = 1'b1;
            if (rtr_acc) busy = 1'b1;
        end
    endtask

    initial begin
        for (int q = 0; q < NPE; q++)
            for (int o = 0; o < (1 << OFF_W); o++) begin
                shadow[q][o] = '0;
                mem[q][o]    = '0;
            end
        for (int p = 0; p < NPE; p++) begin
            acc[p] = 0; waitr[p] = 0; first[p] = 0; chk[p] = 0;
        end
        bank_rdata = '0;
        repeat (3) @(negedge clk);
        // R8: quiet outputs under reset
        nchk++; if (resp_valid !== '0) fail("R8 resp_valid in reset", DATA_W'(resp_valid), 0);
        nchk++; if (bank_en !== '0)    fail("R8 bank_en in reset", DATA_W'(bank_en), 0);
        nchk++; if (rtr_valid !== 1'b0) fail("R8 rtr_valid in reset", DATA_W'(rtr_valid), 0);
        rst = 1'b0;
        run_phase(0, 1);   // R2: every element writes its own bank at once
        run_phase(1, 1);   // R2, R4: own-bank readback
        run_phase(2, 1);   // R3, R5: all elements hit bank 5
        run_phase(3, 1);   // R6: all elements go off-cluster together
        run_phase(4, 60);  // mixed random traffic
        // R4: written words landed in the right bank and offset
        for (int q = 0; q < NPE; q++)
            for (int o = 0; o < (1 << OFF_W); o++) begin
                nchk++;
                if (mem[q][o] !== shadow[q][o])
                    fail($sformatf("R4 bank %0d word %0d", q, o), mem[q][o], shadow[q][o]);
            end
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            nchk++;
            nfail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", nchk - nfail, nchk);
            $finish;
        end
    end
endmodule